// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a small, fully associative translation buffer. Each slot maps a pair of neighbouring virtual pages, one even and one odd, onto two physical frame numbers. Each page of the pair has its own cache attribute, dirty flag and valid flag. A slot also holds a per-slot page mask and a global flag. Mask bits set to one exclude the matching tag bits from the compare. The global flag makes the slot answer to every address-space identifier.

Two independent compare ports read the array in the same cycle they are driven. The lookup port returns a hit flag, the winning slot and both packed page words. The probe port returns the winning slot, or minus one when no slot answers. A write port loads one whole slot on the next clock edge. A flush input empties the array. A round-robin victim pointer advances on each accepted write, so that a caller can use it to pick the next slot to fill. Translation policy, fault signalling and table walking are left to the surrounding logic.

Top module: `tlbp_top`

## Requirements
- R1: A slot matches a request page number when the two agree on every bit where the slot's mask is 0. Bits where the mask is 1 are ignored.
- R2: When the slot's global flag is 0, the request identifier must equal the slot identifier for a match. When the flag is 1, the identifier is not compared.
- R3: A slot takes part in matching only while its even valid flag or its odd valid flag is 1.
- R4: When several slots match, the lowest slot number is reported on both compare ports.
- R5: Lookup is combinational. On a hit, lk_hit is 1, lk_idx gives the slot, and each page word is packed as {PFN, attribute[2:0], dirty, valid, global}, with global at bit 0, valid at bit 1, dirty at bit 2, attribute at bits 5:3 and PFN from bit 6 up. On a miss, lk_hit, lk_idx and both words are 0.
- R6: Probe is combinational. pr_idx is the matching slot with its top bit 0. When no slot matches, pr_idx is all ones (minus one).
- R7: A write with wr_en high loads the addressed slot on the next rising edge and fully replaces the slot's previous contents. Before that edge, the old contents remain visible.
- R8: A write whose slot number is at or above the entry count changes no slot and does not move the victim pointer.
- R9: Flush clears every slot to all zeros and sets the victim pointer to 0 on the next edge. When flush and a write arrive in the same cycle, the flush wins.
- R10: Synchronous active-low reset has the same effect as a flush.
- R11: The victim pointer advances by one for each accepted write and wraps from the last slot to 0.
- R12: The readback port returns the tag, identifier, mask and both packed page words of the slot named by rd_slot, in the packed form of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear all slots |
| wr_en | input | 1 | Write strobe |
| wr_slot | input | 5 | Target slot (may be out of range) |
| wr_tag | input | 19 | Page-pair number tag |
| wr_asid | input | 8 | Address-space identifier |
| wr_g | input | 1 | Global flag |
| wr_mask | input | 19 | Page mask, 1 = ignore bit |
| wr_pfn_e | input | 20 | Even page frame number |
| wr_attr_e | input | 3 | Even page cache attribute |
| wr_dirty_e | input | 1 | Even page dirty flag |
| wr_valid_e | input | 1 | Even page valid flag |
| wr_pfn_o | input | 20 | Odd page frame number |
| wr_attr_o | input | 3 | Odd page cache attribute |
| wr_dirty_o | input | 1 | Odd page dirty flag |
| wr_valid_o | input | 1 | Odd page valid flag |
| lk_vpn | input | 19 | Lookup page-pair number |
| lk_asid | input | 8 | Lookup identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Lookup winning slot |
| lk_even_word | output | 26 | Packed even page word |
| lk_odd_word | output | 26 | Packed odd page word |
| pr_vpn | input | 19 | Probe page-pair number |
| pr_asid | input | 8 | Probe identifier |
| pr_idx | output | 5 | Probe result, all ones when not found |
| rd_slot | input | 4 | Readback slot |
| rd_tag | output | 19 | Readback tag |
| rd_asid | output | 8 | Readback identifier |
| rd_mask | output | 19 | Readback mask |
| rd_even_word | output | 26 | Readback packed even word |
| rd_odd_word | output | 26 | Readback packed odd word |
| victim_idx | output | 4 | Round-robin fill pointer |

## Verification
The bench loads two slots that overlap through a mask, so the request matches both. A design that scans from the top, or that ORs the candidates together, then reports the wrong slot or a mixed word. It also loads a slot with both valid flags clear whose tag equals a request. A design that forgets the presence rule hits on that slot. It also loads a global slot that must hit under any identifier, and a masked request that differs only in an unmasked bit. The remaining directed cases cover four corners: writes to slots 16 and 31, which a design with truncated slot decoding would alias onto real slots; a flush in the same cycle as a write, where the wrong priority leaves one slot loaded; the victim pointer wrapping after sixteen writes; and readback one moment before the write edge, which catches a design that lets write data through combinationally.

// File: rtl/tlbp_pkg.sv
// Shared widths, slot layout and word packing for the paired-page buffer.
// Assumes a fixed page-pair number, identifier and frame width for the chip.
package tlbp_pkg;
    localparam int VPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 20;
    localparam int ATTR_W = 3;
    localparam int WORD_W = PFN_W + ATTR_W + 3;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } page_t;

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [VPN_W-1:0]  mask;
        page_t             even;
        page_t             odd;
    } slot_t;

    // Packs one page with the slot's global flag into the readback word
    function automatic logic [WORD_W-1:0] pack_word(page_t p, logic g);
        return {p.pfn, p.attr, p.dirty, p.valid, g};
    endfunction
endpackage

// File: rtl/tlbp_match.sv
// Per-slot comparator bank: one match line per slot.
// Assumes the slot array is held as a packed vector by the caller.
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int N = 16
) (
    input  slot_t [N-1:0]    slots,
    input  logic [VPN_W-1:0] vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [N-1:0]     hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic tag_eq, id_ok, present;
        // Compare unmasked tag bits, identifier or global, and presence
        always_comb begin
            tag_eq     = ((vpn ^ slots[i].tag) & ~slots[i].mask) == '0;
            id_ok      = slots[i].glob || (asid == slots[i].asid);
            present    = slots[i].even.valid || slots[i].odd.valid;
            hit_vec[i] = tag_eq && id_ok && present;
        end
    end
endmodule

// File: rtl/tlbp_prio.sv
// Lowest-index-first priority picker over a request vector.
// Assumes N >= 1; idx is 0 when nothing is requested.
module tlbp_prio #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set request is kept last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    p_pick_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req[idx]);
    p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
    p_none_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !found);
endmodule

// File: rtl/tlbp_top.sv
// Paired-page fully associative translation buffer: slot storage, write
// and flush control, round-robin victim pointer, lookup, probe and readback.
// Assumes single-clock use; compare ports are combinational on storage.
module tlbp_top
    import tlbp_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int SLOT_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [VPN_W-1:0]   wr_tag,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_g,
    input  logic [VPN_W-1:0]   wr_mask,
    input  logic [PFN_W-1:0]   wr_pfn_e,
    input  logic [ATTR_W-1:0]  wr_attr_e,
    input  logic               wr_dirty_e,
    input  logic               wr_valid_e,
    input  logic [PFN_W-1:0]   wr_pfn_o,
    input  logic [ATTR_W-1:0]  wr_attr_o,
    input  logic               wr_dirty_o,
    input  logic               wr_valid_o,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [WORD_W-1:0]  lk_even_word,
    output logic [WORD_W-1:0]  lk_odd_word,
    input  logic [VPN_W-1:0]   pr_vpn,
    input  logic [ASID_W-1:0]  pr_asid,
    output logic [SLOT_W-1:0]  pr_idx,
    input  logic [IDX_W-1:0]   rd_slot,
    output logic [VPN_W-1:0]   rd_tag,
    output logic [ASID_W-1:0]  rd_asid,
    output logic [VPN_W-1:0]   rd_mask,
    output logic [WORD_W-1:0]  rd_even_word,
    output logic [WORD_W-1:0]  rd_odd_word,
    output logic [IDX_W-1:0]   victim_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    slot_t [N_ENTRIES-1:0] slots;
    slot_t                 wr_data;
    logic                  wr_ok;
    logic [N_ENTRIES-1:0]  lk_vec, pr_vec;
    logic                  pr_found;
    logic [IDX_W-1:0]      pr_pick;
    slot_t                 lk_slot, rd_ent;

    // Assemble the incoming slot and qualify the write by range
    always_comb begin
        wr_data.tag   = wr_tag;
        wr_data.asid  = wr_asid;
        wr_data.glob  = wr_g;
        wr_data.mask  = wr_mask;
        wr_data.even  = '{pfn: wr_pfn_e, attr: wr_attr_e, dirty: wr_dirty_e, valid: wr_valid_e};
        wr_data.odd   = '{pfn: wr_pfn_o, attr: wr_attr_o, dirty: wr_dirty_o, valid: wr_valid_o};
        wr_ok         = wr_en && (32'(wr_slot) < N_ENTRIES);
    end

    // Slot storage: reset and flush clear all, else load the addressed slot
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            slots <= '0;
        end else if (wr_ok) begin
            slots[wr_slot[IDX_W-1:0]] <= wr_data;
        end
    end

    // Victim pointer: cleared with the array, steps on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            victim_idx <= '0;
        end else if (wr_ok) begin
            victim_idx <= (victim_idx == LAST) ? '0 : victim_idx + 1'b1;
        end
    end

    tlbp_match #(.N(N_ENTRIES)) u_lk_cmp (
        .slots(slots), .vpn(lk_vpn), .asid(lk_asid), .hit_vec(lk_vec));
    tlbp_match #(.N(N_ENTRIES)) u_pr_cmp (
        .slots(slots), .vpn(pr_vpn), .asid(pr_asid), .hit_vec(pr_vec));
    tlbp_prio #(.N(N_ENTRIES)) u_lk_pick (
        .clk(clk), .rst_n(rst_n), .req(lk_vec), .found(lk_hit), .idx(lk_idx));
    tlbp_prio #(.N(N_ENTRIES)) u_pr_pick (
        .clk(clk), .rst_n(rst_n), .req(pr_vec), .found(pr_found), .idx(pr_pick));

    // Lookup words: packed pages of the winner, zero on a miss
    always_comb begin
        lk_slot      = slots[lk_idx];
        lk_even_word = lk_hit ? pack_word(lk_slot.even, lk_slot.glob) : '0;
        lk_odd_word  = lk_hit ? pack_word(lk_slot.odd,  lk_slot.glob) : '0;
        pr_idx       = pr_found ? {1'b0, pr_pick} : '1;
    end

    // Readback of one slot in packed form
    always_comb begin
        rd_ent       = slots[rd_slot];
        rd_tag       = rd_ent.tag;
        rd_asid      = rd_ent.asid;
        rd_mask      = rd_ent.mask;
        rd_even_word = pack_word(rd_ent.even, rd_ent.glob);
        rd_odd_word  = pack_word(rd_ent.odd,  rd_ent.glob);
    end

    p_hit_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_even_word[1] || lk_odd_word[1]));
    p_oob_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(flush) && (32'($past(wr_slot)) >= N_ENTRIES))
        |-> ($stable(slots) && $stable(victim_idx)));
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush)) |-> (slots == '0 && victim_idx == '0));
    p_victim_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ok) && !$past(flush))
        |-> (victim_idx == (($past(victim_idx) == LAST) ? '0 : $past(victim_idx) + 1'b1)));
    p_probe_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_vpn == lk_vpn && pr_asid == lk_asid)
        |-> (lk_hit ? (pr_idx == {1'b0, lk_idx}) : (pr_idx == '1)));
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_even_word == '0 && lk_odd_word == '0 && lk_idx == '0));
endmodule

// File: tb/sim_tlbp_top.sv
module sim_tlbp_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [18:0] vpn;
        logic [7:0]  asid;
        logic        hit;
        logic [3:0]  idx;
        logic [3:0]  rq;
    } vec_t;

    // Lookup vectors against the loaded set (see directed setup below)
    localparam vec_t VECS [0:11] = '{
        '{19'h00100, 8'd5, 1'b1, 4'd0, 4'd1},  // R1 exact tag
        '{19'h00100, 8'd6, 1'b0, 4'd0, 4'd2},  // R2 identifier mismatch
        '{19'h00200, 8'd0, 1'b1, 4'd1, 4'd2},  // R2 global any id
        '{19'h00200, 8'd7, 1'b1, 4'd1, 4'd2},  // R2 global own id
        '{19'h0030A, 8'd5, 1'b1, 4'd2, 4'd1},  // R1 masked low bits
        '{19'h00305, 8'd5, 1'b1, 4'd2, 4'd4},  // R4 slots 2 and 3 both match
        '{19'h00310, 8'd5, 1'b0, 4'd0, 4'd1},  // R1 unmasked bit differs
        '{19'h00400, 8'd5, 1'b0, 4'd0, 4'd3},  // R3 both valid flags clear
        '{19'h00500, 8'd9, 1'b1, 4'd5, 4'd3},  // R3 odd valid only
        '{19'h00300, 8'd6, 1'b1, 4'd9, 4'd2},  // R2 only slot 9 id fits
        '{19'h00301, 8'd6, 1'b0, 4'd0, 4'd1},  // R1 slot 9 has no mask
        '{19'h00101, 8'd5, 1'b0, 4'd0, 4'd1}   // R1 off by one
    };

    logic        clk = 0, rst_n = 0, flush = 0, wr_en = 0;
    logic [4:0]  wr_slot = 0;
    logic [18:0] wr_tag = 0, wr_mask = 0, lk_vpn = 0, pr_vpn = 0;
    logic [7:0]  wr_asid = 0, lk_asid = 0, pr_asid = 0;
    logic        wr_g = 0, wr_dirty_e = 0, wr_valid_e = 0, wr_dirty_o = 0, wr_valid_o = 0;
    logic [19:0] wr_pfn_e = 0, wr_pfn_o = 0;
    logic [2:0]  wr_attr_e = 0, wr_attr_o = 0;
    logic [3:0]  rd_slot = 0;
    logic        lk_hit;
    logic [3:0]  lk_idx, victim_idx;
    logic [25:0] lk_even_word, lk_odd_word, rd_even_word, rd_odd_word;
    logic [4:0]  pr_idx;
    logic [18:0] rd_tag, rd_mask;
    logic [7:0]  rd_asid;

    int n_chk = 0, n_bad = 0;
    logic [25:0] sh_even [16];
    logic [25:0] sh_odd  [16];

    always #(CLK_P/2) clk = ~clk;

    tlbp_top u0 (.*);

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [25:0] word(logic [19:0] pfn, logic [2:0] c, logic d, logic v, logic g);
        return {pfn, c, d, v, g};
    endfunction

    task automatic wr(input logic [4:0] s, input logic [18:0] tag, input logic [7:0] id,
                      input logic g, input logic [18:0] m, input logic [19:0] pe,
                      input logic [2:0] ce, input logic de, input logic ve,
                      input logic [19:0] po, input logic [2:0] co, input logic dd, input logic vo);
        @(negedge clk);
        wr_slot = s; wr_tag = tag; wr_asid = id; wr_g = g; wr_mask = m;
        wr_pfn_e = pe; wr_attr_e = ce; wr_dirty_e = de; wr_valid_e = ve;
        wr_pfn_o = po; wr_attr_o = co; wr_dirty_o = dd; wr_valid_o = vo;
        wr_en = 1;
        if (s < 16) begin
            sh_even[s[3:0]] = word(pe, ce, de, ve, g);
            sh_odd[s[3:0]]  = word(po, co, dd, vo, g);
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input logic [18:0] v, input logic [7:0] a);
        @(negedge clk);
        lk_vpn = v; lk_asid = a; pr_vpn = v; pr_asid = a;
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state empties array and pointer
        chk("R10", "victim after reset", 32'(victim_idx), 0);
        for (int s = 0; s < 16; s++) begin
            rd_slot = 4'(s); #1;
            chk("R10", "slot zero after reset", {6'd0, rd_even_word} | {6'd0, rd_odd_word} | 32'(rd_tag), 0);
        end
        look(19'h0, 8'h0);
        chk("R10", "zero slot not hit", 32'(lk_hit), 0);
        chk("R6", "probe not found", 32'(pr_idx), 32'h1F);

        // R7: write becomes visible only after the edge
        @(negedge clk);
        wr_slot = 0; wr_tag = 19'h00100; wr_asid = 5; wr_g = 0; wr_mask = 0;
        wr_pfn_e = 20'h11111; wr_attr_e = 3; wr_dirty_e = 1; wr_valid_e = 1;
        wr_pfn_o = 20'h22222; wr_attr_o = 2; wr_dirty_o = 0; wr_valid_o = 1;
        wr_en = 1; rd_slot = 0; #1;
        chk("R7", "old tag before edge", 32'(rd_tag), 0);
        @(posedge clk); #1;
        wr_en = 0;
        chk("R7", "new tag after edge", 32'(rd_tag), 32'h100);
        sh_even[0] = word(20'h11111, 3, 1, 1, 0);
        sh_odd[0]  = word(20'h22222, 2, 0, 1, 0);

        wr(1, 19'h00200, 7, 1, 19'h0,  20'h33333, 1, 0, 1, 20'h0, 0, 0, 0);
        wr(2, 19'h00300, 5, 0, 19'hF,  20'h44444, 4, 1, 1, 20'h55555, 5, 1, 1);
        wr(3, 19'h00305, 5, 0, 19'h0,  20'h66666, 6, 0, 1, 20'h77777, 7, 0, 1);
        wr(4, 19'h00400, 5, 0, 19'h0,  20'h88888, 0, 1, 0, 20'h99999, 0, 1, 0);
        wr(5, 19'h00500, 9, 0, 19'h0,  20'h0,     0, 0, 0, 20'hAAAAA, 3, 1, 1);
        wr(9, 19'h00300, 6, 0, 19'h0,  20'hBBBBB, 2, 1, 1, 20'hCCCCC, 1, 0, 1);
        // R11: seven accepted writes
        chk("R11", "victim after 7 writes", 32'(victim_idx), 7);

        // R12: readback of a masked slot
        rd_slot = 2; #1;
        chk("R12", "rd tag", 32'(rd_tag), 32'h300);
        chk("R12", "rd asid", 32'(rd_asid), 5);
        chk("R12", "rd mask", 32'(rd_mask), 32'hF);
        chk("R12", "rd even word", 32'(rd_even_word), 32'(word(20'h44444, 4, 1, 1, 0)));

        // R1 R2 R3 R4 R5 R6: vector walk
        for (int i = 0; i < 12; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            look(VECS[i].vpn, VECS[i].asid);
            chk(t, "hit", 32'(lk_hit), 32'(VECS[i].hit));
            chk(t, "idx", 32'(lk_idx), 32'(VECS[i].idx));
            if (VECS[i].hit) begin
                chk(t, "even word R5", 32'(lk_even_word), 32'(sh_even[VECS[i].idx]));
                chk(t, "odd word R5", 32'(lk_odd_word), 32'(sh_odd[VECS[i].idx]));
                chk(t, "probe R6", 32'(pr_idx), 32'(VECS[i].idx));
            end else begin
                chk(t, "miss words R5", 32'(lk_even_word | lk_odd_word), 0);
                chk(t, "probe -1 R6", 32'(pr_idx), 32'h1F);
            end
        end

        // R8: out-of-range writes ignored
        wr(16, 19'h00777, 5, 1, 19'h0, 20'h1, 1, 1, 1, 20'h2, 1, 1, 1);
        wr(31, 19'h00777, 5, 1, 19'h0, 20'h1, 1, 1, 1, 20'h2, 1, 1, 1);
        chk("R8", "victim unchanged", 32'(victim_idx), 7);
        look(19'h00777, 8'd5);
        chk("R8", "ignored tag not hit", 32'(lk_hit), 0);
        rd_slot = 0; #1;
        chk("R8", "slot 0 intact", 32'(rd_tag), 32'h100);

        // R7: replacement of an occupied slot
        wr(0, 19'h00700, 5, 0, 19'h0, 20'hDDDDD, 5, 1, 1, 20'hEEEEE, 6, 1, 1);
        look(19'h00100, 8'd5);
        chk("R7", "old occupant gone", 32'(lk_hit), 0);
        look(19'h00700, 8'd5);
        chk("R7", "new occupant idx", 32'(lk_idx), 0);
        chk("R7", "new occupant word", 32'(lk_odd_word), 32'(word(20'hEEEEE, 6, 1, 1, 0)));
        chk("R11", "victim after 8", 32'(victim_idx), 8);

        // R9: flush beats simultaneous write
        @(negedge clk);
        flush = 1; wr_en = 1; wr_slot = 3; wr_tag = 19'h00999; wr_valid_e = 1;
        @(negedge clk);
        flush = 0; wr_en = 0;
        chk("R9", "victim after flush", 32'(victim_idx), 0);
        rd_slot = 3; #1;
        chk("R9", "slot 3 cleared", 32'(rd_tag) | 32'(rd_even_word), 0);
        look(19'h00200, 8'd0);
        chk("R9", "global slot gone", 32'(lk_hit), 0);

        // R11: wrap after a full round
        for (int s = 0; s < 16; s++)
            wr(5'(s), 19'h01000 + 19'(s), 1, 0, 19'h0, 20'(s), 0, 0, 1, 20'h0, 0, 0, 0);
        chk("R11", "victim wrapped", 32'(victim_idx), 0);
        wr(4, 19'h02000, 1, 0, 19'h0, 20'h5, 0, 0, 1, 20'h0, 0, 0, 0);
        chk("R11", "victim after wrap+1", 32'(victim_idx), 1);

        // R10: mid-run reset clears like flush
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_slot = 7; #1;
        chk("R10", "slot 7 cleared", 32'(rd_tag), 0);
        chk("R10", "victim cleared", 32'(victim_idx), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule